// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Compare Channels

This block is a slow-running timebase for a low-power domain. A one-cycle enable from a 32.768 kHz source drives a programmable divider. Each time the divider completes, a free-running counter advances by one. The counter is compared against several programmable match values. The block raises sticky flags for three kinds of source: a counter step, a counter wrap and a compare match. From those flags it drives one combined interrupt line. It also emits one-clock pulses that other logic can route.

Software controls the block through a small word-addressed register bus. Three write-one command slots start, halt and zero the counter. Interrupt enables and pulse-routing enables are two separate masks. Each mask is changed through its own pair of set and clear slots, and writing 1 to a bit acts on that bit. Each flag is cleared by writing 0 to its slot. The divider value only accepts writes while the counter is halted.

Source bit order, used in every mask and in `evt_pulse`: bit 0 step, bit 1 wrap, bit 2+n compare channel n. Byte addresses: 0x00 start, 0x04 halt, 0x08 zero, 0x10/0x14 interrupt-enable set/clear, 0x18/0x1C pulse-enable set/clear, 0x20+4k flag of source k, 0x40 divider, 0x44 counter value, 0x50+4n compare value n.

Top module: `lp_rtc`

## Requirements
- R1: After reset the counter, divider, both masks, every flag, every compare value, `irq` and `evt_pulse` are zero, and the counter is halted.
- R2: While running, the counter advances by one on every (D+1)-th `lf_tick` pulse, where D is the divider value (12 bits, 0 to 4095).
- R3: A write with data bit 0 set to 0x00 starts counting, to 0x04 halts it, and to 0x08 zeroes the counter and the divider phase. A write with bit 0 clear to any of these slots has no effect. A halted counter holds its value.
- R4: A write to the divider slot 0x40 is ignored while the counter runs; reading 0x40 returns the divider value.
- R5: Reading 0x44 returns the counter value at any time; read data appears on `bus_rdata` one clock after the read request.
- R6: Writing 1 to bit k at 0x10 sets interrupt-enable bit k, and writing 1 at 0x14 clears it. A 0 bit leaves the enable unchanged. Reading either slot returns the interrupt-enable mask.
- R7: Slots 0x18/0x1C set and clear the pulse-enable mask in the same way, independently of the interrupt-enable mask. Reading either slot returns the pulse-enable mask.
- R8: The step flag (0x20) becomes 1 on every counter advance and stays 1. Writing 0 to its slot clears it, and writing 1 leaves it unchanged.
- R9: The wrap flag (0x24) becomes 1 when the counter advances from all ones (0xFFFFFF at default width) to zero.
- R10: The flag of compare channel n (0x28+4n) becomes 1 when the counter advances to a value equal to compare value n (0x50+4n). Writing a compare value equal to the present count does not set the flag.
- R11: `irq` is 1 exactly when some flag and its interrupt enable are both 1, and it follows the flags and enables with one clock of delay.
- R12: `evt_pulse[k]` is high for one clock when source k fires and its pulse enable is 1. It appears on the same clock edge that sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle enable at the low-frequency rate |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| evt_pulse | output | NUM_CC+2 | One-clock source pulses for routing |

## Verification
A register write takes effect at the clock edge that samples it, and read data is due one edge after the request. The bench therefore samples read data at the falling edge after the request cycle. A counter step, with its flag and any routed pulse, lands on the edge that samples `lf_tick`. The bench raises `lf_tick` for exactly one cycle and inspects `evt_pulse` at the following falling edge. `irq` is registered once more, so the bench waits one extra cycle after changing an enable or a flag before it checks `irq`. Wrap is exercised with a narrower counter so the full range fits in the run.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;

  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] A_RUN      = 8'h00;
  localparam logic [BUS_AW-1:0] A_HALT     = 8'h04;
  localparam logic [BUS_AW-1:0] A_ZERO     = 8'h08;
  localparam logic [BUS_AW-1:0] A_IEN_SET  = 8'h10;
  localparam logic [BUS_AW-1:0] A_IEN_CLR  = 8'h14;
  localparam logic [BUS_AW-1:0] A_EEN_SET  = 8'h18;
  localparam logic [BUS_AW-1:0] A_EEN_CLR  = 8'h1C;
  localparam logic [BUS_AW-1:0] A_FLAG0    = 8'h20;
  localparam logic [BUS_AW-1:0] A_DIV      = 8'h40;
  localparam logic [BUS_AW-1:0] A_COUNT    = 8'h44;
  localparam logic [BUS_AW-1:0] A_CMP0     = 8'h50;

  localparam int SRC_STEP = 0;
  localparam int SRC_WRAP = 1;
  localparam int SRC_CMP0 = 2;

  function automatic logic [BUS_AW-1:0] slot(input logic [BUS_AW-1:0] base, input int idx);
    return base + BUS_AW'(idx * 4);
  endfunction

endpackage

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
  import lp_rtc_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 24,
  parameter int NUM_CC  = 4,
  parameter int NSRC    = NUM_CC + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [BUS_AW-1:0]       bus_addr,
  input  logic [BUS_DW-1:0]       bus_wdata,
  output logic [BUS_DW-1:0]       bus_rdata,
  input  logic                    run,
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic [NSRC-1:0]         flags,
  output logic                    t_start,
  output logic                    t_stop,
  output logic                    t_clear,
  output logic [PRESC_W-1:0]      presc,
  output logic [NSRC-1:0]         ien,
  output logic [NSRC-1:0]         een,
  output logic [NUM_CC*CNT_W-1:0] cmp_flat,
  output logic [NSRC-1:0]         flag_clr
);

  logic wr, rd;
  logic unused_wdata;
  logic [BUS_DW-1:0] rmux;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;
  assign unused_wdata = ^bus_wdata;

  assign t_start = wr && (bus_addr == A_RUN)  && bus_wdata[0];
  assign t_stop  = wr && (bus_addr == A_HALT) && bus_wdata[0];
  assign t_clear = wr && (bus_addr == A_ZERO) && bus_wdata[0];

  always_comb begin
    for (int k = 0; k < NSRC; k++)
      flag_clr[k] = wr && (bus_addr == slot(A_FLAG0, k)) && !bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      een <= '0;
    end else if (wr) begin
      if (bus_addr == A_IEN_SET) ien <= ien | bus_wdata[NSRC-1:0];
      if (bus_addr == A_IEN_CLR) ien <= ien & ~bus_wdata[NSRC-1:0];
      if (bus_addr == A_EEN_SET) een <= een | bus_wdata[NSRC-1:0];
      if (bus_addr == A_EEN_CLR) een <= een & ~bus_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      presc <= '0;
    else if (wr && (bus_addr == A_DIV) && !run)
      presc <= bus_wdata[PRESC_W-1:0];
  end

  for (genvar n = 0; n < NUM_CC; n++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)
        cmp_flat[n*CNT_W +: CNT_W] <= '0;
      else if (wr && (bus_addr == slot(A_CMP0, n)))
        cmp_flat[n*CNT_W +: CNT_W] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == A_IEN_SET || bus_addr == A_IEN_CLR) rmux = BUS_DW'(ien);
    if (bus_addr == A_EEN_SET || bus_addr == A_EEN_CLR) rmux = BUS_DW'(een);
    if (bus_addr == A_DIV)   rmux = BUS_DW'(presc);
    if (bus_addr == A_COUNT) rmux = BUS_DW'(cnt_val);
    for (int k = 0; k < NSRC; k++)
      if (bus_addr == slot(A_FLAG0, k)) rmux = BUS_DW'(flags[k]);
    for (int n = 0; n < NUM_CC; n++)
      if (bus_addr == slot(A_CMP0, n)) rmux = BUS_DW'(cmp_flat[n*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd)
      bus_rdata <= rmux;
  end

endmodule

// File: rtl/lp_rtc_core.sv
module lp_rtc_core #(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lf_tick,
  input  logic               t_start,
  input  logic               t_stop,
  input  logic               t_clear,
  input  logic [PRESC_W-1:0] presc,
  output logic               run,
  output logic [CNT_W-1:0]   cnt,
  output logic               inc
);

  logic [PRESC_W-1:0] phase;
  logic               phase_end;

  // >= guards a divider lowered while the phase sat above it
  assign phase_end = (phase >= presc);
  assign inc       = run && lf_tick && phase_end && !t_clear;

  always_ff @(posedge clk) begin
    if (rst)          run <= 1'b0;
    else if (t_start) run <= 1'b1;
    else if (t_stop)  run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || t_clear) begin
      phase <= '0;
      cnt   <= '0;
    end else if (run && lf_tick) begin
      if (phase_end) begin
        phase <= '0;
        cnt   <= cnt + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lp_rtc_events.sv
module lp_rtc_events
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CC = 4,
  parameter int NSRC   = NUM_CC + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inc,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [NUM_CC*CNT_W-1:0] cmp_flat,
  input  logic [NSRC-1:0]         flag_clr,
  input  logic [NSRC-1:0]         ien,
  input  logic [NSRC-1:0]         een,
  output logic [NSRC-1:0]         fire,
  output logic [NSRC-1:0]         flags,
  output logic [NSRC-1:0]         evt_pulse,
  output logic                    irq
);

  logic [CNT_W-1:0] cnt_up;
  assign cnt_up = cnt + 1'b1;

  assign fire[SRC_STEP] = inc;
  assign fire[SRC_WRAP] = inc && (&cnt);

  for (genvar n = 0; n < NUM_CC; n++) begin : g_match
    assign fire[SRC_CMP0+n] = inc && (cnt_up == cmp_flat[n*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      evt_pulse <= '0;
      irq       <= 1'b0;
    end else begin
      for (int k = 0; k < NSRC; k++) begin
        if (fire[k])          flags[k] <= 1'b1;
        else if (flag_clr[k]) flags[k] <= 1'b0;
      end
      evt_pulse <= fire & een;
      irq       <= |(flags & ien);
    end
  end

endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 24,
  parameter int NUM_CC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lf_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [NUM_CC+1:0] evt_pulse
);

  localparam int NSRC = NUM_CC + 2;

  logic                    run, inc;
  logic                    t_start, t_stop, t_clear;
  logic [PRESC_W-1:0]      presc;
  logic [CNT_W-1:0]        cnt_val;
  logic [NSRC-1:0]         ien, een, flags, fire, flag_clr;
  logic [NUM_CC*CNT_W-1:0] cmp_flat;

  lp_rtc_regs #(
    .PRESC_W(PRESC_W), .CNT_W(CNT_W), .NUM_CC(NUM_CC), .NSRC(NSRC)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run(run), .cnt_val(cnt_val), .flags(flags),
    .t_start(t_start), .t_stop(t_stop), .t_clear(t_clear),
    .presc(presc), .ien(ien), .een(een),
    .cmp_flat(cmp_flat), .flag_clr(flag_clr)
  );

  lp_rtc_core #(
    .PRESC_W(PRESC_W), .CNT_W(CNT_W)
  ) u_core (
    .clk(clk), .rst(rst), .lf_tick(lf_tick),
    .t_start(t_start), .t_stop(t_stop), .t_clear(t_clear),
    .presc(presc), .run(run), .cnt(cnt_val), .inc(inc)
  );

  lp_rtc_events #(
    .CNT_W(CNT_W), .NUM_CC(NUM_CC), .NSRC(NSRC)
  ) u_events (
    .clk(clk), .rst(rst), .inc(inc), .cnt(cnt_val),
    .cmp_flat(cmp_flat), .flag_clr(flag_clr),
    .ien(ien), .een(een),
    .fire(fire), .flags(flags), .evt_pulse(evt_pulse), .irq(irq)
  );

endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk #(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 24,
  parameter int NSRC    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               t_clear,
  input logic [PRESC_W-1:0] presc,
  input logic [CNT_W-1:0]   cnt_val,
  input logic [NSRC-1:0]    fire,
  input logic [NSRC-1:0]    flags,
  input logic [NSRC-1:0]    ien,
  input logic [NSRC-1:0]    evt_pulse,
  input logic               irq
);

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(presc));                                       // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !t_clear) |=> $stable(cnt_val));                      // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    fire[0] |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));       // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    fire[1] |=> (cnt_val == '0));                                  // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == '0 && $past(ien) == '0) |-> !irq);                     // R11

  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse & ~flags) == '0);                                   // R12

endmodule

bind lp_rtc lp_rtc_chk #(
  .PRESC_W(PRESC_W), .CNT_W(CNT_W), .NSRC(NUM_CC + 2)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .t_clear(t_clear), .presc(presc),
  .cnt_val(cnt_val), .fire(fire), .flags(flags), .ien(ien),
  .evt_pulse(evt_pulse), .irq(irq)
);

// File: tb/test_lp_rtc.sv
module test_lp_rtc;

  localparam int CW = 8;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lf_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [NC+1:0] evt_pulse;

  int checks = 0;
  int fails  = 0;
  logic [NC+1:0] seen;

  always #10 clk = ~clk;

  lp_rtc #(.PRESC_W(12), .CNT_W(CW), .NUM_CC(NC)) i_lp_rtc (
    .clk(clk), .rst(rst), .lf_tick(lf_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic lft(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lf_tick = 1'b1;
      @(negedge clk);
      lf_tick = 1'b0;
      seen = seen | evt_pulse;
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 count", 8'h44, 0);
    rd_chk("R1 div", 8'h40, 0);
    rd_chk("R1 ien", 8'h10, 0);
    rd_chk("R1 een", 8'h18, 0);
    rd_chk("R1 step flag", 8'h20, 0);
    rd_chk("R1 cmp3 value", 8'h5C, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 evt_pulse", 32'(evt_pulse), 0);
  endtask

  task automatic t_masks;
    wr(8'h10, 32'h5);
    rd_chk("R6 set then read clr slot", 8'h14, 32'h5);
    wr(8'h14, 32'h1);
    rd_chk("R6 clear one bit", 8'h10, 32'h4);
    wr(8'h10, 32'h0);
    rd_chk("R6 zero write no effect", 8'h10, 32'h4);
    wr(8'h18, 32'h2);
    rd_chk("R7 pulse mask set", 8'h1C, 32'h2);
    rd_chk("R7 irq mask independent", 8'h14, 32'h4);
    wr(8'h1C, 32'h3F);
    wr(8'h14, 32'h3F);
    rd_chk("R7 pulse mask cleared", 8'h18, 0);
  endtask

  task automatic t_run_div;
    wr(8'h04, 1);
    wr(8'h40, 2);
    rd_chk("R4 div writable when halted", 8'h40, 2);
    wr(8'h08, 1);
    wr(8'h00, 0);
    lft(3);
    rd_chk("R3 start with bit0 clear ignored", 8'h44, 0);
    wr(8'h00, 1);
    lft(3);
    rd_chk("R2 first step after D+1 ticks", 8'h44, 1);
    lft(2);
    rd_chk("R2 no step before D+1 ticks", 8'h44, 1);
    lft(1);
    rd_chk("R5 count readable while running", 8'h44, 2);
    wr(8'h40, 0);
    rd_chk("R4 div write ignored while running", 8'h40, 2);
    wr(8'h04, 1);
    lft(4);
    rd_chk("R3 halted counter holds", 8'h44, 2);
    wr(8'h08, 0);
    rd_chk("R3 zero with bit0 clear ignored", 8'h44, 2);
    wr(8'h08, 1);
    rd_chk("R3 zero task", 8'h44, 0);
  endtask

  task automatic t_step_flag;
    wr(8'h40, 0);
    wr(8'h20, 0);
    wr(8'h00, 1);
    lft(1);
    wr(8'h04, 1);
    rd_chk("R8 step flag set", 8'h20, 1);
    wr(8'h20, 1);
    rd_chk("R8 write one keeps flag", 8'h20, 1);
    wr(8'h20, 0);
    rd_chk("R8 write zero clears flag", 8'h20, 0);
  endtask

  task automatic t_wrap;
    wr(8'h08, 1);
    wr(8'h24, 0);
    wr(8'h00, 1);
    lft((1 << CW) - 1);
    rd_chk("R9 count at all ones", 8'h44, (1 << CW) - 1);
    rd_chk("R9 no wrap yet", 8'h24, 0);
    lft(1);
    wr(8'h04, 1);
    rd_chk("R9 count wrapped to zero", 8'h44, 0);
    rd_chk("R9 wrap flag set", 8'h24, 1);
  endtask

  task automatic t_compare;
    wr(8'h08, 1);
    wr(8'h28, 0);
    wr(8'h50, 5);
    wr(8'h00, 1);
    lft(4);
    rd_chk("R10 no match before value", 8'h28, 0);
    lft(1);
    wr(8'h04, 1);
    rd_chk("R10 match on reaching value", 8'h28, 1);
    rd_chk("R10 count at match", 8'h44, 5);
    wr(8'h2C, 0);
    wr(8'h54, 5);
    repeat (3) @(negedge clk);
    rd_chk("R10 equal write does not fire", 8'h2C, 0);
    wr(8'h34, 0);
    wr(8'h5C, 7);
    wr(8'h00, 1);
    lft(2);
    wr(8'h04, 1);
    rd_chk("R10 channel 3 match", 8'h34, 1);
  endtask

  task automatic t_irq;
    @(negedge clk);
    chk("R11 irq low with no enables", {31'd0, irq}, 0);
    wr(8'h10, 32'h4);
    @(negedge clk);
    chk("R11 irq from cmp0 flag", {31'd0, irq}, 1);
    wr(8'h28, 0);
    @(negedge clk);
    chk("R11 irq drops after flag clear", {31'd0, irq}, 0);
    wr(8'h14, 32'h3F);
  endtask

  task automatic t_pulse;
    wr(8'h08, 1);
    wr(8'h18, 32'h1);
    seen = '0;
    wr(8'h00, 1);
    lft(1);
    chk("R12 step pulse routed", 32'(seen), 32'h1);
    @(negedge clk);
    chk("R12 pulse lasts one clock", 32'(evt_pulse), 0);
    wr(8'h1C, 32'h1);
    seen = '0;
    lft(1);
    chk("R12 no pulse when disabled", 32'(seen), 0);
    wr(8'h04, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    seen = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masks();
    t_run_div();
    t_step_flag();
    t_wrap();
    t_compare();
    t_irq();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule